// File: doc/BRIEF.md
# Dithered High-Resolution DAC Driver

This block sits beside an output pin and feeds the 9-bit input code of the pin's DAC. A controller writes one configuration word that turns the DAC mode on or off and sets a static 16-bit output level. While the mode is on, the block picks one of two neighbouring 9-bit codes on every clock. Over each 128-clock frame, the average of the codes it picks equals the 16-bit level. A 9-bit converter, followed by ordinary analog filtering, can therefore reach close to 16-bit average precision.

The upper nine bits of the level form a base code. The seven low bits give the number of clocks in the frame on which the code is one step above the base. A bit-reversed view of the frame position decides which clocks those are. This spreads the raised clocks evenly across the frame instead of grouping them at its start. A configuration word is held until the next frame boundary, so every frame averages to exactly one level. Any controller may issue the write. The port carries whichever write arrives last.

Top module: `dac_dither_drv`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `dac_code` is 0. The frame position starts at 0 on that first cycle.
- R2: While the active mode is off (`cfg_dac_en` was 0 in the word in force), `dac_code` is 0 on every clock.
- R3: While the active mode is on, `dac_code` is either the base code (level bits 15..7) or base+1 on every clock.
- R4: With the mode on and a base below 511, the sum of `dac_code` over one frame is exactly 128·base + fraction, where the fraction is level bits 6..0. With the mode off, the sum is 0.
- R5: At frame position p (0..127, counting clocks from the frame start), the code is base+1 exactly when the 7-bit bit-reversal of p is less than the fraction. For example, fraction 64 raises every even position and fraction 1 raises only position 0.
- R6: When the base code is 511, base+1 saturates, so `dac_code` stays at 511 for the whole frame.
- R7: A write made at any position other than 127 has no effect on the current frame. It takes effect at position 0 of the next frame.
- R8: A write presented on the clock of position 127 takes effect at position 0 of the very next frame.
- R9: When several writes land in one frame, only the last one takes effect at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Configuration write strobe, one clock per word |
| cfg_dac_en | input | 1 | DAC mode in the written word: 1 on, 0 off |
| cfg_level | input | 16 | Static output level in the written word |
| dac_code | output | 9 | Code to the DAC input |

## Verification
A frame counter that slips shows up within one frame. The raised clocks then fall at the wrong positions, and the per-frame sum changes. A shadow register that loads outside the boundary shows up on the next clock, because the code changes in the middle of a frame. A missing saturation shows up on the first raised clock of a level near full scale: the code wraps to 0. The bench compares every clock's code against its own model and sums each frame, so each of these faults appears within at most 128 clocks of its cause.

// File: rtl/dac_dither_pkg.sv
`timescale 1ns/1ps
package dac_dither_pkg;
  localparam int unsigned DEF_LEVEL_W = 16;
  localparam int unsigned DEF_CODE_W  = 9;

  typedef enum logic {
    MODE_OFF = 1'b0,
    MODE_DAC = 1'b1
  } dac_mode_e;
endpackage

// File: rtl/dac_frame_ctr.sv
`timescale 1ns/1ps
module dac_frame_ctr #(
  parameter int unsigned POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos,
  output logic             last
);
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos  = pos_q;
  assign last = &pos_q;
endmodule

// File: rtl/dac_cfg_stage.sv
`timescale 1ns/1ps
module dac_cfg_stage
  import dac_dither_pkg::*;
#(
  parameter int unsigned LEVEL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_dac_en,
  input  logic [LEVEL_W-1:0] cfg_level,
  input  logic               frame_last,
  output logic               act_mode,
  output logic [LEVEL_W-1:0] act_level
);
  dac_mode_e          pend_mode_q, pend_mode_d, act_mode_q, act_mode_d;
  logic [LEVEL_W-1:0] pend_level_q, pend_level_d, act_level_q, act_level_d;
  logic               pend_en, act_en;
  dac_mode_e          wr_mode;

  always_comb begin
    wr_mode      = cfg_dac_en ? MODE_DAC : MODE_OFF;
    pend_en      = cfg_wr;
    pend_mode_d  = wr_mode;
    pend_level_d = cfg_level;
    act_en       = frame_last;
    if (cfg_wr) begin
      act_mode_d  = wr_mode;
      act_level_d = cfg_level;
    end else begin
      act_mode_d  = pend_mode_q;
      act_level_d = pend_level_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_mode_q  <= MODE_OFF;
      pend_level_q <= '0;
    end else if (pend_en) begin
      pend_mode_q  <= pend_mode_d;
      pend_level_q <= pend_level_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode_q  <= MODE_OFF;
      act_level_q <= '0;
    end else if (act_en) begin
      act_mode_q  <= act_mode_d;
      act_level_q <= act_level_d;
    end
  end

  assign act_mode  = (act_mode_q == MODE_DAC);
  assign act_level = act_level_q;
endmodule

// File: rtl/dac_dither_sel.sv
`timescale 1ns/1ps
module dac_dither_sel #(
  parameter int unsigned LEVEL_W = 16,
  parameter int unsigned CODE_W  = 9,
  localparam int unsigned FRAC_W = LEVEL_W - CODE_W
) (
  input  logic               act_mode,
  input  logic [LEVEL_W-1:0] act_level,
  input  logic [FRAC_W-1:0]  pos,
  output logic [CODE_W-1:0]  dac_code
);
  logic [FRAC_W-1:0] pos_rev;
  logic [FRAC_W-1:0] frac;
  logic [CODE_W-1:0] base, base_up;
  logic              raise;

  for (genvar i = 0; i < FRAC_W; i++) begin : g_rev
    assign pos_rev[i] = pos[FRAC_W-1-i];
  end

  always_comb begin
    base    = act_level[LEVEL_W-1 -: CODE_W];
    frac    = act_level[FRAC_W-1:0];
    base_up = (&base) ? base : base + CODE_W'(1);
    raise   = (pos_rev < frac);
    if (!act_mode)  dac_code = '0;
    else if (raise) dac_code = base_up;
    else            dac_code = base;
  end
endmodule

// File: rtl/dac_dither_drv.sv
`timescale 1ns/1ps
module dac_dither_drv
  import dac_dither_pkg::*;
#(
  parameter int unsigned LEVEL_W = DEF_LEVEL_W,
  parameter int unsigned CODE_W  = DEF_CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_dac_en,
  input  logic [LEVEL_W-1:0] cfg_level,
  output logic [CODE_W-1:0]  dac_code
);
  localparam int unsigned FRAC_W = LEVEL_W - CODE_W;

  logic [FRAC_W-1:0]  frame_pos;
  logic               frame_last;
  logic               act_mode;
  logic [LEVEL_W-1:0] act_level;

  dac_frame_ctr #(.POS_W(FRAC_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .pos   (frame_pos),
    .last  (frame_last)
  );

  dac_cfg_stage #(.LEVEL_W(LEVEL_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_dac_en (cfg_dac_en),
    .cfg_level  (cfg_level),
    .frame_last (frame_last),
    .act_mode   (act_mode),
    .act_level  (act_level)
  );

  dac_dither_sel #(.LEVEL_W(LEVEL_W), .CODE_W(CODE_W)) u_sel (
    .act_mode  (act_mode),
    .act_level (act_level),
    .pos       (frame_pos),
    .dac_code  (dac_code)
  );
endmodule

// File: rtl/dac_dither_chk.sv
`timescale 1ns/1ps
module dac_dither_chk #(
  parameter int unsigned LEVEL_W = 16,
  parameter int unsigned CODE_W  = 9,
  localparam int unsigned FRAC_W = LEVEL_W - CODE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CODE_W-1:0]  dac_code,
  input logic               act_mode,
  input logic [LEVEL_W-1:0] act_level,
  input logic [FRAC_W-1:0]  frame_pos
);
  logic [CODE_W-1:0] base;
  logic [FRAC_W:0]   hits_q;
  logic              hit_now;

  assign base    = act_level[LEVEL_W-1 -: CODE_W];
  assign hit_now = act_mode && (dac_code != base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hits_q <= '0;
    else if (&frame_pos) hits_q <= '0;
    else if (hit_now)    hits_q <= hits_q + (FRAC_W+1)'(1);
  end

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !act_mode |-> dac_code == '0); // R2

  AST_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    act_mode |-> (dac_code == base || dac_code == base + CODE_W'(1) || dac_code == '1)); // R3

  AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode && !(&base) && (&frame_pos))
      |-> (hits_q + (FRAC_W+1)'(hit_now)) == {1'b0, act_level[FRAC_W-1:0]}); // R4

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> frame_pos == FRAC_W'($past(frame_pos) + FRAC_W'(1))); // R5

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode && (&base)) |-> (&dac_code)); // R6

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pos != '0) |-> ($stable(act_level) && $stable(act_mode))); // R7
endmodule

bind dac_dither_drv dac_dither_chk #(.LEVEL_W(LEVEL_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dac_code  (dac_code),
  .act_mode  (act_mode),
  .act_level (act_level),
  .frame_pos (frame_pos)
);

// File: tb/dac_dither_drv_bench.sv
`timescale 1ns/1ps
module dac_dither_drv_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic        cfg_dac_en;
  logic [15:0] cfg_level;
  logic [8:0]  dac_code;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model
  int unsigned m_pos;
  bit          m_mode, p_mode;
  logic [15:0] m_lvl, p_lvl;
  int unsigned fsum;
  string       dir_tag = "";

  always #4 clk = ~clk;

  dac_dither_drv u_dac_dither_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_dac_en (cfg_dac_en),
    .cfg_level  (cfg_level),
    .dac_code   (dac_code)
  );

  function automatic int unsigned rev7(input int unsigned p);
    int unsigned r = 0;
    for (int i = 0; i < 7; i++) if (p[i]) r = r | (1 << (6 - i));
    return r;
  endfunction

  function automatic int unsigned exp_code(input bit md, input logic [15:0] lv, input int unsigned p);
    int unsigned b = lv[15:7];
    int unsigned f = lv[6:0];
    if (!md) return 0;
    if (rev7(p) < f) return (b == 511) ? 511 : b + 1;
    return b;
  endfunction

  function automatic int unsigned exp_sum(input bit md, input logic [15:0] lv);
    int unsigned b = lv[15:7];
    if (!md) return 0;
    if (b == 511) return 511 * 128;
    return b * 128 + lv[6:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (pos %0d level %h mode %0d)",
               tag, act, exp, m_pos, m_lvl, m_mode);
    end
  endtask

  task automatic check_cycle();
    int unsigned e = exp_code(m_mode, m_lvl, m_pos);
    string tag;
    if (dir_tag != "")        tag = dir_tag;
    else if (!m_mode)         tag = "R2";
    else if (m_lvl[15:7] == 511) tag = "R6";
    else                      tag = "R5";
    chk(dac_code == e, tag, dac_code, e);
    if (m_mode) chk(dac_code == m_lvl[15:7] || dac_code == m_lvl[15:7] + 1 || dac_code == 511,
                    "R3", dac_code, m_lvl[15:7]);
    fsum += dac_code;
    if (m_pos == 127) begin
      chk(fsum == exp_sum(m_mode, m_lvl), "R4", fsum, exp_sum(m_mode, m_lvl));
      fsum = 0;
    end
  endtask

  task automatic step(input bit wr, input bit md, input logic [15:0] lv);
    cfg_wr = wr; cfg_dac_en = md; cfg_level = lv;
    if (m_pos == 127) begin
      if (wr) begin m_mode = md; m_lvl = lv; end
      else    begin m_mode = p_mode; m_lvl = p_lvl; end
    end
    if (wr) begin p_mode = md; p_lvl = lv; end
    @(posedge clk);
    @(negedge clk);
    m_pos = (m_pos + 1) % 128;
    cfg_wr = 1'b0;
    check_cycle();
  endtask

  task automatic idle_to(input int unsigned p);
    while (m_pos != p) step(1'b0, 1'b0, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lv;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_dac_en = 1'b0; cfg_level = '0;
    m_pos = 0; m_mode = 0; m_lvl = 0; p_mode = 0; p_lvl = 0; fsum = 0;
    repeat (3) @(negedge clk);
    chk(dac_code == 0, "R1", dac_code, 0);
    rst_n = 1'b1;
    dir_tag = "R1";
    check_cycle();
    dir_tag = "";

    // R7: mid-frame write leaves the rest of this frame unchanged (mode off)
    idle_to(20);
    dir_tag = "R7";
    step(1'b1, 1'b1, 16'h8040);        // base 256, fraction 64
    idle_to(0);
    // R5: fraction 64 raises every even position
    dir_tag = "R5";
    idle_to(127);
    // R8: write on position 127 applies to the next frame
    dir_tag = "R8";
    step(1'b1, 1'b1, 16'h0301);        // base 6, fraction 1
    idle_to(127);
    // R9: two writes in a frame, last one wins
    dir_tag = "R9";
    idle_to(10);
    step(1'b1, 1'b1, 16'h1234);
    idle_to(60);
    step(1'b1, 1'b1, 16'hFFC5);        // base 511 saturates
    idle_to(0);
    dir_tag = "R6";
    idle_to(127);
    dir_tag = "R4";
    step(1'b1, 1'b1, 16'h007F);        // base 0, fraction 127
    idle_to(127);
    step(1'b1, 1'b1, 16'hFF7F);        // base 510, fraction 127
    idle_to(127);
    dir_tag = "R2";
    step(1'b1, 1'b0, 16'hABCD);        // mode off with nonzero level
    idle_to(127);
    dir_tag = "";

    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 39) == 0) begin
        case ($urandom_range(0, 5))
          0:       lv = 16'hFFFF;
          1:       lv = {7'($urandom), 9'h000} & 16'hFF80;
          2:       lv = 16'($urandom) | 16'h007F;
          default: lv = 16'($urandom);
        endcase
        step(1'b1, ($urandom_range(0, 7) != 0), lv);
      end else begin
        step(1'b0, 1'b0, 16'h0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule